// File: doc/BRIEF.md
# Datapath Self-Test Controller with Pseudorandom Source and CRC Signature

This block sits at the head of a converter's digital datapath and can take that datapath over for a self-test. In normal operation, converter samples arrive on a valid/ready input stream, pass through a one-stage formatting register and leave on a valid/ready output stream. A small register interface has a control register and a status register. A write to the control register with the enable bit set starts a test. For the test, a 12-bit pseudorandom word generator replaces the converter samples at the datapath input.

While the test runs, every word that leaves the datapath is folded into a 16-bit CRC signature. The output bus keeps carrying these words, so the pseudorandom stream can be watched from outside. After a fixed number of test words has left the datapath, the controller compares the signature with a golden constant, records pass or fail in the status register, and hands the datapath back to the converter. The generator can either be reseeded at the start of a test or left to continue from where the previous test stopped. Only a reseeded test can match the golden value.

Back-pressure rules: a word moves on a stream when valid and ready are both high at a rising edge. While valid is high and ready is low, the producer holds its word. The input is ready whenever the formatting stage is empty or its output is being accepted in the same cycle. During a test the input is never ready. Back-pressure on the output lengthens a test but does not change the words, their order or the signature.

Top module: `dp_bist_ctrl`

## Requirements
- R1: The control register is at address 0. Bit 0 is the enable bit: writing it as 1 while idle starts a test, and it reads back as 1 while a test runs. Bit 2 is the reseed request: it is stored on every accepted write and reads back as written. A write with bit 0 at 0 stores bit 2 and starts nothing. The status register is at address 1: bit 0 is pass, bit 1 is done and bit 2 is busy. Reads are combinational.
- R2: While idle, an accepted input word appears on `out_data` with `out_valid` high after exactly one rising edge. Word order is kept. `smp_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R3: During a test `smp_ready` stays low and the generator feeds the datapath. Each word is the current generator state, and the state then steps as `s' = {s[10:0], s[11]^s[5]^s[3]^s[0]}`. After a reseed, the first test word is the seed value 0xACE.
- R4: Each test delivers exactly 512 generator words to the output. With `out_ready` held high, `bist_busy` is high for 513 cycles, counted from the edge that captures the start write: 512 words plus one stage of latency.
- R5: The signature starts at 0xFFFF at the start of a test. For each test word at the output, it takes the word's 12 bits MSB first, using CRC polynomial 0x1021 with no reflection and no final XOR. At the edge where the last word leaves, done is set and pass is set only if the signature equals the golden parameter.
- R6: A test started with bit 2 at 0 resumes the generator. Its first word is the successor of the last word of the previous test. The signature then differs from the golden value, so pass reads 0 while done reads 1.
- R7: Starting a test clears pass and done.
- R8: Writes to the control register while a test runs are ignored. They neither restart nor stop the test, and they do not change the stored reseed bit.
- R9: After reset the block is idle: `bist_busy`, `bist_pass` and `out_valid` are low, both registers read 0, and the generator holds the seed.
- R10: Output back-pressure during a test leaves the word sequence and the pass result unchanged. It only lengthens the time `bist_busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Converter sample ready |
| smp_data | input | 12 | Converter sample |
| out_valid | output | 1 | Datapath output valid |
| out_ready | input | 1 | Datapath output ready |
| out_data | output | 12 | Datapath output word |
| bist_busy | output | 1 | Test in progress |
| bist_pass | output | 1 | Last test signature matched |

## Verification
Register reads are combinational. The effect of a write can be seen after the next rising edge. An idle word is due one edge after the handshake that accepts it. With no stalls, busy falls and pass/done become valid 513 edges after the edge that captures the start write. The bench drives and samples 1 ns after each rising edge, so these edge counts map one-to-one onto its loop iterations. It captures output handshakes on the falling edge, where valid, ready and data are settled. Under back-pressure the bench checks only the words and the result, not a fixed cycle count.

// File: rtl/dbist_pkg.sv
package dbist_pkg;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_STAT     = 1;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INIT_BIT = 2;
  localparam int STAT_PASS_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
  localparam int STAT_BUSY_BIT = 2;
endpackage

// File: rtl/pn_word_gen.sv
module pn_word_gen #(
  parameter int          W    = 12,
  parameter logic [W-1:0] TAPS = 12'h829,
  parameter logic [W-1:0] SEED = 12'hACE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] word
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb   = ^(state_q & TAPS);
  assign word = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED;
    else if (load) state_q <= SEED;
    else if (step) state_q <= {state_q[W-2:0], fb};
  end

  // R3: a nonzero LFSR state never collapses to zero
  assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R3: every step moves to a different state
  assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (state_q != $past(state_q)));
endmodule

// File: rtl/sig_crc.sv
module sig_crc #(
  parameter int              DATA_W = 12,
  parameter int              CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  sig,
  output logic [CRC_W-1:0]  sig_next
);
  logic [CRC_W-1:0] sig_q;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = sig_q;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    sig_next = c;
  end

  assign sig = sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sig_q <= INIT;
    else if (clear) sig_q <= INIT;
    else if (upd)   sig_q <= sig_next;
  end
endmodule

// File: rtl/fmt_stage.sv
module fmt_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_tag,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_tag
);
  logic         v_q;
  logic [W-1:0] d_q;
  logic         t_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;
  assign out_tag   = t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
      t_q <= 1'b0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        d_q <= in_data;
        t_q <= in_tag;
      end
    end
  end

  // R2: a stalled output word is held unchanged
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dp_bist_ctrl.sv
module dp_bist_ctrl
  import dbist_pkg::*;
#(
  parameter int                 DATA_W     = 12,
  parameter int                 RUN_LEN    = 512,
  parameter int                 CRC_W      = 16,
  parameter logic [CRC_W-1:0]   CRC_POLY   = 16'h1021,
  parameter logic [DATA_W-1:0]  PN_TAPS    = 12'h829,
  parameter logic [DATA_W-1:0]  PN_SEED    = 12'hACE,
  parameter logic [CRC_W-1:0]   GOLDEN_SIG = 16'h0000,
  parameter int                 REG_W      = 8,
  parameter int                 ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              bist_busy,
  output logic              bist_pass
);
  localparam int                CNT_W    = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0]  RUN_END  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(RUN_LEN - 1);

  logic             busy_q, done_q, pass_q, init_q;
  logic [CNT_W-1:0] inj_cnt, out_cnt;

  logic              ctrl_wr, start, reseed;
  logic              pn_valid, pn_fire;
  logic [DATA_W-1:0] pn_word;
  logic              st_in_valid, st_in_ready, st_in_tag, st_out_tag;
  logic [DATA_W-1:0] st_in_data;
  logic              test_out_fire, last_word;
  logic [CRC_W-1:0]  sig_now, sig_upd;
  logic              unused_bits;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL)) && !busy_q;
  assign start   = ctrl_wr && reg_wdata[CTRL_EN_BIT];
  assign reseed  = start && reg_wdata[CTRL_INIT_BIT];

  // source select: generator while testing, converter otherwise
  assign pn_valid    = busy_q && (inj_cnt != RUN_END);
  assign st_in_valid = busy_q ? pn_valid : smp_valid;
  assign st_in_data  = busy_q ? pn_word  : smp_data;
  assign st_in_tag   = busy_q;
  assign smp_ready   = !busy_q && st_in_ready;
  assign pn_fire     = pn_valid && st_in_ready;

  assign test_out_fire = out_valid && out_ready && st_out_tag;
  assign last_word     = test_out_fire && (out_cnt == LAST_IDX);

  pn_word_gen #(.W(DATA_W), .TAPS(PN_TAPS), .SEED(PN_SEED)) u_pn (
    .clk  (clk),
    .rst_n(rst_n),
    .load (reseed),
    .step (pn_fire),
    .word (pn_word)
  );

  fmt_stage #(.W(DATA_W)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (st_in_valid),
    .in_ready (st_in_ready),
    .in_data  (st_in_data),
    .in_tag   (st_in_tag),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_tag  (st_out_tag)
  );

  sig_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT('1)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .upd     (test_out_fire),
    .din     (out_data),
    .sig     (sig_now),
    .sig_next(sig_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      init_q  <= 1'b0;
      inj_cnt <= '0;
      out_cnt <= '0;
    end else begin
      if (ctrl_wr) init_q <= reg_wdata[CTRL_INIT_BIT];
      if (start) begin
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        pass_q  <= 1'b0;
        inj_cnt <= '0;
        out_cnt <= '0;
      end else begin
        if (pn_fire)       inj_cnt <= inj_cnt + 1'b1;
        if (test_out_fire) out_cnt <= out_cnt + 1'b1;
        if (last_word) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pass_q <= (sig_upd == GOLDEN_SIG);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata[CTRL_EN_BIT]   = busy_q;
      reg_rdata[CTRL_INIT_BIT] = init_q;
    end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
      reg_rdata[STAT_PASS_BIT] = pass_q;
      reg_rdata[STAT_DONE_BIT] = done_q;
      reg_rdata[STAT_BUSY_BIT] = busy_q;
    end
  end

  assign bist_busy   = busy_q;
  assign bist_pass   = pass_q;
  assign unused_bits = ^{reg_wdata, sig_now};

  // R3: converter samples are held off for the whole test
  assert_no_sample_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !smp_ready);
  // R7: a new test begins with pass and done cleared
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (!pass_q && !done_q));
  // R4: test words only appear at the output while a test runs
  assert_tag_in_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && st_out_tag) |-> busy_q);
  // R8: control writes during a test leave the stored reseed bit alone
  assert_ctrl_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(init_q));
endmodule

// File: tb/dp_bist_ctrl_bench.sv
module dp_bist_ctrl_bench;
  localparam int          RUN   = 512;
  localparam logic [11:0] SEED  = 12'hACE;

  function automatic logic [11:0] m_next(input logic [11:0] s);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [11:0] d);
    logic [15:0] r;
    logic        f;
    r = c;
    for (int i = 11; i >= 0; i--) begin
      f = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (f) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [15:0] gold_calc();
    logic [11:0] s;
    logic [15:0] c;
    s = SEED;
    c = 16'hFFFF;
    for (int i = 0; i < RUN; i++) begin
      c = m_crc(c, s);
      s = m_next(s);
    end
    return c;
  endfunction

  localparam logic [15:0] GOLD = gold_calc();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_data = 12'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;
  logic        bist_busy;
  logic        bist_pass;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [11:0] cap [0:1023];
  int          cap_n = 0;
  logic [11:0] m_lfsr = SEED;
  logic [11:0] exp_w [0:RUN-1];

  always #2 clk = ~clk;

  dp_bist_ctrl #(.GOLDEN_SIG(GOLD)) u_dp_bist_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .bist_busy(bist_busy),
    .bist_pass(bist_pass)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && cap_n < 1024) begin
      cap[cap_n] = out_data;
      cap_n++;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired: actual %0d cycles, expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv,
                     input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  // run one test; returns busy cycle count
  task automatic run_test(input bit init, input bit stall, input bit poke,
                          input bit feed, input string req, output int busy_n);
    logic [15:0] c;
    logic [7:0]  v;
    int          bad;
    if (init) m_lfsr = SEED;
    c = 16'hFFFF;
    for (int i = 0; i < RUN; i++) begin
      exp_w[i] = m_lfsr;
      c        = m_crc(c, m_lfsr);
      m_lfsr   = m_next(m_lfsr);
    end
    cap_n = 0;
    wr(2'd0, init ? 8'h05 : 8'h01);
    busy_n = 0;
    while (bist_busy && busy_n < 5000) begin
      busy_n++;
      if (stall) out_ready = (busy_n % 3) != 0;
      if (feed) begin smp_valid = 1'b1; smp_data = 12'hFFF; end
      if (poke && busy_n == 100) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; end
      else if (poke && busy_n == 200) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h05; end
      else reg_wr = 1'b0;
      if (busy_n == 10) begin
        if (feed) chk("R3", {31'd0, smp_ready}, 32'd0, "input ready during test");
        rd(2'd1, v);
        chk("R7", {31'd0, v[0]}, 32'd0, "pass cleared at start");
        chk("R7", {31'd0, v[1]}, 32'd0, "done cleared at start");
        rd(2'd0, v);
        chk("R1", {31'd0, v[0]}, 32'd1, "enable reads 1 while running");
      end
      step();
    end
    reg_wr = 1'b0;
    smp_valid = 1'b0;
    out_ready = 1'b1;
    step();
    chk("R4", cap_n, RUN, {req, " words delivered"});
    bad = 0;
    for (int i = 0; i < RUN; i++) if (cap[i] !== exp_w[i]) bad++;
    chk(req, bad, 0, "mismatching stream words");
    chk("R3", {20'd0, cap[0]}, {20'd0, exp_w[0]}, "first test word");
    rd(2'd1, v);
    chk("R5", {31'd0, v[1]}, 32'd1, "done after test");
    chk("R5", {31'd0, v[0]}, {31'd0, (c == GOLD)}, "pass vs model signature");
    chk("R5", {31'd0, bist_pass}, {31'd0, (c == GOLD)}, "bist_pass pin");
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R9", {31'd0, bist_busy}, 32'd0, "busy after reset");
    chk("R9", {31'd0, bist_pass}, 32'd0, "pass after reset");
    chk("R9", {31'd0, out_valid}, 32'd0, "out_valid after reset");
    rd(2'd0, v); chk("R9", v, 8'h00, "control after reset");
    rd(2'd1, v); chk("R9", v, 8'h00, "status after reset");
  endtask

  task automatic t_seed_after_reset();
    int n;
    // resume right after reset starts from the seed, so it matches
    run_test(1'b0, 1'b0, 1'b0, 1'b0, "R9", n);
    chk("R9", {20'd0, cap[0]}, {20'd0, SEED}, "first word after reset");
    chk("R9", {31'd0, bist_pass}, 32'd1, "resume-after-reset pass");
  endtask

  task automatic t_passthru();
    smp_valid = 1'b1; smp_data = 12'h123; out_ready = 1'b1;
    #0.5; chk("R2", {31'd0, smp_ready}, 32'd1, "ready when empty");
    step();
    chk("R2", {31'd0, out_valid}, 32'd1, "valid one edge after accept");
    chk("R2", {20'd0, out_data}, 32'h123, "first word");
    smp_data = 12'h456; out_ready = 1'b0;
    #0.5; chk("R2", {31'd0, smp_ready}, 32'd0, "not ready when full and stalled");
    step();
    chk("R2", {20'd0, out_data}, 32'h123, "held under stall");
    out_ready = 1'b1;
    step();
    chk("R2", {20'd0, out_data}, 32'h456, "second word in order");
    smp_valid = 1'b0;
    step();
    chk("R2", {31'd0, out_valid}, 32'd0, "drained");
  endtask

  task automatic t_seeded();
    int n;
    run_test(1'b1, 1'b0, 1'b0, 1'b1, "R3", n);
    chk("R4", n, 513, "busy cycles without stalls");
    chk("R5", {31'd0, bist_pass}, 32'd1, "seeded run passes");
  endtask

  task automatic t_resume();
    int          n;
    logic [11:0] nxt;
    logic [7:0]  v;
    nxt = m_next(exp_w[RUN-1]);
    run_test(1'b0, 1'b0, 1'b0, 1'b0, "R6", n);
    chk("R6", {20'd0, cap[0]}, {20'd0, nxt}, "resumed first word");
    rd(2'd1, v);
    chk("R6", {31'd0, v[0]}, 32'd0, "resumed run fails");
    chk("R6", {31'd0, v[1]}, 32'd1, "resumed run done");
  endtask

  task automatic t_stall();
    int n;
    run_test(1'b1, 1'b1, 1'b0, 1'b0, "R10", n);
    chk("R10", {31'd0, bist_pass}, 32'd1, "pass under back-pressure");
    chk("R10", {31'd0, (n > 513)}, 32'd1, "busy lengthened by stalls");
  endtask

  task automatic t_ignore();
    int         n;
    logic [7:0] v;
    run_test(1'b1, 1'b0, 1'b1, 1'b0, "R8", n);
    chk("R8", n, 513, "busy length with writes during test");
    chk("R8", {31'd0, bist_pass}, 32'd1, "pass with writes during test");
    rd(2'd0, v);
    chk("R8", {31'd0, v[2]}, 32'd1, "reseed bit unchanged");
    wr(2'd0, 8'h00);
    chk("R1", {31'd0, bist_busy}, 32'd0, "write without enable starts nothing");
    rd(2'd0, v);
    chk("R1", v, 8'h00, "reseed bit stored when idle");
    wr(2'd0, 8'h04);
    rd(2'd0, v);
    chk("R1", v, 8'h04, "bit 2 reads back");
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_seed_after_reset();
    t_passthru();
    t_seeded();
    t_resume();
    t_stall();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule